// File: doc/BRIEF.md
# Fault-secure ECC word memory

This block stores 7-bit data words in a 16-entry array, each held as a 15-bit codeword of a cyclic majority-decodable code. The code has minimum distance 5. On a write, the block latches the data and encodes it. A syndrome detector then examines the encoded word before the word may enter storage. If the detector reports a problem, the block encodes the data again. After a fixed number of failed attempts it gives up and raises a sticky fault flag. The write port follows a valid/ready handshake, so the block holds off new writes while an encode is in progress or while the fault flag is set.

Every read goes through a one-step majority-logic corrector, whether or not the stored word holds an error. A second syndrome detector watches the corrector output. It flags any word that is still not a codeword, including a word damaged by the corrector itself. Three test-only XOR masks let a bench inject bit flips at three points: the encoder output, the storage read path and the corrector output.

The codeword keeps the data in bits 14:8. Bits 7:0 hold the remainder of x^8·d(x) divided by g(x) = 1 + x^4 + x^6 + x^7 + x^8. Parity check row s covers bit positions (s, s+1, s+3, s+7) mod 15. Bit i is flipped when at least three of the four rows that contain it fail.

Top module: `fsecc_mem`

## Requirements
- R1: While reset is held and after it is released, wr_ready is 1, enc_fault is 0 and rd_valid is 0. Every entry reads back as data 0 with rd_error 0.
- R2: When wr_valid and wr_ready are both high at a clock edge, the block accepts wr_data for entry wr_addr. If the encoder is fault-free, wr_ready is low for exactly one cycle, and later reads of that entry return the data.
- R3: A read requested by rd_en at a clock edge produces rd_valid, rd_data and rd_error in the following cycle. rd_valid lasts one cycle for each request.
- R4: Any one or two flipped bits between storage and the corrector leave rd_data equal to the stored data, with rd_error 0.
- R5: An encoded word that fails the detector is not stored, and the data is encoded again. When a later attempt passes, that word is stored. In that case wr_ready stays low for one cycle per attempt.
- R6: When three attempts in a row fail, the write is dropped and the entry keeps its old contents. enc_fault then goes to 1 and stays there. wr_ready stays low until fault_clear is sampled high, and it is 1 again in the next cycle.
- R7: If the corrector output is corrupted with 1 to 4 flipped bits, rd_error is 1 for that read.
- R8: While wr_ready is low, the block ignores wr_valid and leaves storage unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Block can accept a write |
| wr_addr | input | 4 | Write entry |
| wr_data | input | 7 | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | 4 | Read entry |
| rd_valid | output | 1 | Read result present |
| rd_data | output | 7 | Corrected read data |
| rd_error | output | 1 | Corrector output failed its check |
| enc_fault | output | 1 | Sticky: encode retries used up |
| fault_clear | input | 1 | Clears enc_fault |
| inj_enc_mask | input | 15 | Test XOR on encoder output |
| inj_mem_mask | input | 15 | Test XOR on storage read path |
| inj_cor_mask | input | 15 | Test XOR on corrector output |

## Verification
A read result is due one cycle after the edge that samples rd_en. The bench raises rd_en and the read masks at a falling edge and checks the outputs at the next falling edge. Each encode attempt takes one cycle. The bench counts the falling edges at which wr_ready is still low after the handshake and expects that count to equal the number of attempts. It holds the encoder mask until exactly the chosen number of attempts have seen it. A dropped write and an ignored request are confirmed by reading the entry back. The fault flag and its clearing are checked one cycle after the edge that changes them.

// File: rtl/fsecc_mem.sv
module fsecc_mem #(
  parameter int DEPTH     = 16,
  parameter int MAX_TRIES = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_valid,
  output logic                      wr_ready,
  input  logic [$clog2(DEPTH)-1:0]  wr_addr,
  input  logic [6:0]                wr_data,
  input  logic                      rd_en,
  input  logic [$clog2(DEPTH)-1:0]  rd_addr,
  output logic                      rd_valid,
  output logic [6:0]                rd_data,
  output logic                      rd_error,
  output logic                      enc_fault,
  input  logic                      fault_clear,
  input  logic [14:0]               inj_enc_mask,
  input  logic [14:0]               inj_mem_mask,
  input  logic [14:0]               inj_cor_mask
);
  localparam int AW = $clog2(DEPTH);
  localparam int TW = $clog2(MAX_TRIES + 1);
  localparam logic [8:0]  GPOLY = 9'h1D1;
  localparam logic [14:0] CHK   = 15'h008B;

  function automatic logic [14:0] encode(input logic [6:0] d);
    logic [14:0] r;
    r = {d, 8'b0};
    for (int i = 14; i >= 8; i--)
      if (r[i]) r = r ^ (15'(GPOLY) << (i - 8));
    return {d, r[7:0]};
  endfunction

  function automatic logic [14:0] syndrome(input logic [14:0] w);
    logic [14:0] s;
    logic [14:0] row;
    for (int j = 0; j < 15; j++) begin
      row  = (CHK << j) | (CHK >> (15 - j));
      s[j] = ^(w & row);
    end
    return s;
  endfunction

  logic [14:0]   mem [DEPTH];
  logic          busy;
  logic [TW-1:0] tries;
  logic [AW-1:0] lat_addr;
  logic [6:0]    lat_data;

  logic [14:0] enc_cw, raw, syn_raw, corrected, fixed_q, syn_out;
  logic        enc_bad;

  assign wr_ready = !busy && !enc_fault;
  assign enc_cw   = encode(lat_data) ^ inj_enc_mask;
  assign enc_bad  = |syndrome(enc_cw);

  assign raw     = mem[rd_addr] ^ inj_mem_mask;
  assign syn_raw = syndrome(raw);

  for (genvar i = 0; i < 15; i++) begin : g_fix
    logic [2:0] votes;
    assign votes = 3'(syn_raw[i]) + 3'(syn_raw[(i + 14) % 15])
                 + 3'(syn_raw[(i + 12) % 15]) + 3'(syn_raw[(i + 8) % 15]);
    assign corrected[i] = raw[i] ^ (votes >= 3'd3);
  end

  assign fixed_q = corrected ^ inj_cor_mask;
  assign syn_out = syndrome(fixed_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      tries     <= '0;
      enc_fault <= 1'b0;
      lat_addr  <= '0;
      lat_data  <= '0;
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else begin
      if (fault_clear) enc_fault <= 1'b0;
      if (wr_valid && wr_ready) begin
        busy     <= 1'b1;
        tries    <= '0;
        lat_addr <= wr_addr;
        lat_data <= wr_data;
      end else if (busy) begin
        if (!enc_bad) begin
          mem[lat_addr] <= enc_cw;
          busy          <= 1'b0;
        end else if (tries == TW'(MAX_TRIES - 1)) begin
          busy      <= 1'b0;
          enc_fault <= 1'b1;
        end else begin
          tries <= tries + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_error <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      rd_error <= rd_en && (|syn_out);
      if (rd_en) rd_data <= fixed_q[14:8];
    end
  end
endmodule

// File: rtl/fsecc_mem_sva.sv
module fsecc_mem_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic        rd_en,
  input logic        rd_valid,
  input logic        rd_error,
  input logic        enc_fault,
  input logic        fault_clear,
  input logic [14:0] inj_mem_mask,
  input logic [14:0] inj_cor_mask
);
  assert_read_result_due_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  assert_read_only_on_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));

  assert_accept_drops_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !wr_ready);

  assert_fault_blocks_writes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    enc_fault |-> !wr_ready);

  assert_fault_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_fault && !fault_clear) |=> enc_fault);

  assert_clean_read_no_error_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(inj_mem_mask) == 15'd0 && $past(inj_cor_mask) == 15'd0) |-> !rd_error);

  assert_corrupt_output_flagged_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(inj_mem_mask) == 15'd0 && $past(inj_cor_mask) != 15'd0
     && $countones($past(inj_cor_mask)) <= 4) |-> rd_error);
endmodule

bind fsecc_mem fsecc_mem_sva chk_i (.*);

// File: tb/fsecc_mem_tb_top.sv
module fsecc_mem_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [3:0]  wr_addr = '0;
  logic [6:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic        rd_valid;
  logic [6:0]  rd_data;
  logic        rd_error;
  logic        enc_fault;
  logic        fault_clear = 1'b0;
  logic [14:0] inj_enc_mask = '0;
  logic [14:0] inj_mem_mask = '0;
  logic [14:0] inj_cor_mask = '0;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  fsecc_mem dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [6:0] d,
                          input logic [14:0] m, input int nbad, output int low);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    inj_enc_mask = (nbad > 0) ? m : 15'd0;
    @(negedge clk);
    wr_valid = 1'b0;
    low = 0;
    while (!wr_ready && low < 10) begin
      low++;
      if (low == nbad + 1) inj_enc_mask = '0;
      @(negedge clk);
    end
    inj_enc_mask = '0;
  endtask

  task automatic do_read(input logic [3:0] a, input logic [14:0] mm, input logic [14:0] cm,
                         output logic v, output logic [6:0] d, output logic e);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a; inj_mem_mask = mm; inj_cor_mask = cm;
    @(negedge clk);
    rd_en = 1'b0; inj_mem_mask = '0; inj_cor_mask = '0;
    v = rd_valid; d = rd_data; e = rd_error;
  endtask

  initial begin
    #(20ns * 300000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int low;
    logic v, e;
    logic [6:0] d;
    bit ok;

    repeat (3) @(negedge clk);
    chk(wr_ready == 1'b1 && enc_fault == 1'b0 && rd_valid == 1'b0, "R1 in reset",
        {wr_ready, enc_fault, rd_valid}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wr_ready == 1'b1 && enc_fault == 1'b0 && rd_valid == 1'b0, "R1 after reset",
        {wr_ready, enc_fault, rd_valid}, 3'b100);
    for (int a = 0; a < 16; a++) begin
      do_read(4'(a), '0, '0, v, d, e);
      chk(v && d == 7'd0 && !e, "R1 cleared entry", {v, e, d}, 9'b100000000);
    end

    // R2 / R3: every data value, clean path
    for (int x = 0; x < 128; x++) begin
      do_write(4'(x % 16), 7'(x), '0, 0, low);
      chk(low == 1, "R2 ready low cycles", low, 1);
      do_read(4'(x % 16), '0, '0, v, d, e);
      chk(v && d == 7'(x) && !e, "R2 read back", {v, e, d}, {2'b10, 7'(x)});
      if (x == 0) begin
        @(negedge clk);
        chk(rd_valid == 1'b0, "R3 valid one cycle", rd_valid, 0);
      end
    end

    // R4: all single and double storage errors, every data value
    for (int x = 0; x < 128; x++) begin
      do_write(4'd5, 7'(x), '0, 0, low);
      ok = 1'b1;
      for (int p = 0; p < 15; p++)
        for (int q = p; q < 15; q++) begin
          do_read(4'd5, (15'd1 << p) | (15'd1 << q), '0, v, d, e);
          if (!(v && d == 7'(x) && !e)) begin
            ok = 1'b0;
            chk(1'b0, "R4 corrected read", {v, e, d}, {2'b10, 7'(x)});
          end
        end
      if (ok) chk(1'b1, "R4 corrected read", 0, 0);
    end

    // R7: corrupted corrector output
    do_write(4'd3, 7'h55, '0, 0, low);
    for (int p = 0; p < 15; p++)
      for (int q = p; q < 15; q++) begin
        do_read(4'd3, '0, (15'd1 << p) | (15'd1 << q), v, d, e);
        chk(v && e, "R7 output flagged", e, 1);
      end
    do_read(4'd3, '0, 15'h4211, v, d, e);
    chk(v && e, "R7 four-bit corruption flagged", e, 1);

    // R5: encoder faults cleared after one or two attempts
    for (int b = 0; b < 15; b++) begin
      do_write(4'd9, 7'((b * 9 + 1) % 128), 15'd1 << b, 1, low);
      chk(low == 2, "R5 one retry", low, 2);
      do_read(4'd9, '0, '0, v, d, e);
      chk(d == 7'((b * 9 + 1) % 128) && !e, "R5 data after retry", d, (b * 9 + 1) % 128);
    end
    do_write(4'd9, 7'h2A, 15'h0101, 2, low);
    chk(low == 3, "R5 two retries", low, 3);
    do_read(4'd9, '0, '0, v, d, e);
    chk(d == 7'h2A, "R5 data after two retries", d, 7'h2A);

    // R6: three failed attempts abort the write
    do_write(4'd9, 7'h11, 15'h0F00, 3, low);
    chk(low == 10 && enc_fault, "R6 fault raised", {enc_fault, 4'(low)}, {1'b1, 4'd10});
    do_read(4'd9, '0, '0, v, d, e);
    chk(d == 7'h2A, "R6 entry unchanged", d, 7'h2A);

    // R8: writes ignored while blocked
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 4'd9; wr_data = 7'h7F;
    repeat (3) @(negedge clk);
    wr_valid = 1'b0;
    chk(wr_ready == 1'b0 && enc_fault, "R8 still blocked", wr_ready, 0);
    do_read(4'd9, '0, '0, v, d, e);
    chk(d == 7'h2A, "R8 ignored write", d, 7'h2A);

    // R6: clear
    @(negedge clk);
    chk(enc_fault == 1'b1, "R6 fault sticky", enc_fault, 1);
    fault_clear = 1'b1;
    @(negedge clk);
    fault_clear = 1'b0;
    chk(wr_ready == 1'b1 && enc_fault == 1'b0, "R6 cleared", {wr_ready, enc_fault}, 2'b10);
    do_write(4'd9, 7'h33, '0, 0, low);
    chk(low == 1, "R6 write after clear", low, 1);
    do_read(4'd9, '0, '0, v, d, e);
    chk(d == 7'h33 && !e, "R6 data after clear", d, 7'h33);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule